// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block raises a periodic interrupt for a clock-calendar device. Four free-running tick inputs arrive from the prescaler and calendar logic: 4096 Hz, 64 Hz, the seconds-update tick and the minutes-update tick. A two-bit source select picks one of them. An 8-bit reload value sets how many selected ticks make up one period. Each time the down counter runs out, it reloads itself and sets a sticky event flag. If the interrupt enable is on, the flag drives a registered output-enable for an open-drain, active-low interrupt pin.

Software works the block through a small register port. A control register holds the run bit, the interrupt enable and the source select. A reload register holds the period. A status register holds the event flag, which software clears by writing 0.

The tick phase is never reset when the timer is programmed. The first period is therefore between the set time and one source period less than it. Every later period is exact. Example set times are 244.14 µs for a reload of 1 at 4096 Hz, and 3.984 s for a reload of 255 at 64 Hz.

Top module: `cycle_timer_irq`

## Requirements
- R1: After reset the control register, the status flag and `irq_oe` all read 0, and the reload register reads 0.
- R2: Source select value 0 counts `src_ticks[0]` (4096 Hz), 1 counts `src_ticks[1]` (64 Hz), 2 counts `src_ticks[2]` (seconds update) and 3 counts `src_ticks[3]` (minutes update). Pulses on the other three tick inputs have no effect on the count.
- R3: With the run bit at 1 and a reload value N from 1 to 255, the event flag is set on the clock edge that takes the N-th selected tick after the run bit was set. The counter then reloads, so the flag is set again after every further N ticks.
- R4: A reload value of 0 never produces an event, however many ticks arrive.
- R5: The event flag (status address 2, bit 0) is sticky. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R6: `irq_oe` is 1 exactly one clock after the flag and the interrupt enable are both 1. It returns to 0 one clock after either of them falls.
- R7: Setting the interrupt enable while an event is already pending drives `irq_oe` to 1 on the next clock, with no new tick needed.
- R8: Clearing the run bit stops counting and keeps a pending flag. While stopped, the counter holds the reload value, so a restart runs a full period.
- R9: A new reload value written while the timer runs does not change the current period. It applies from the next reload on.
- R10: Register map: address 0 holds run in bit 0, interrupt enable in bit 1 and source select in bits 3:2, with the upper bits reading 0. Address 1 holds the reload value. Address 2 holds the flag in bit 0. Writes take effect on the clock edge where `wr_en` is 1, and reads are combinational on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ticks | input | 4 | Single-cycle tick enables: 4096 Hz, 64 Hz, seconds, minutes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| irq_oe | output | 1 | Open-drain pull-low enable for the interrupt pin |

## Verification
The bench builds the block with its defaults: an 8-bit counter and four tick sources. At this size it can sweep every source select against reload values 1 to 16 and also run the full reload of 255. While one source is selected, the bench pulses each of the other three sources in between the selected ticks. Every expected flag edge is computed from tick counts alone. The same small configuration also reaches the mid-period reload change, the stop with a pending flag, and a late interrupt enable, each within a few hundred cycles.

// File: rtl/cti_pkg.sv
package cti_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_STAT   = 2'd2
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int CTRL_SEL_LSB = 2;
  localparam int STAT_FLAG_BIT = 0;

  // flag update: a new event wins over a clear in the same cycle
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/cti_tick_select.sv
module cti_tick_select #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  always_comb tick = ticks[sel];
endmodule

// File: rtl/cti_down_counter.sv
module cti_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             uflow
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] rl);
    return (cur <= ONE) ? rl : cur - ONE;
  endfunction

  logic [CNT_W-1:0] count_q;

  always_comb uflow = run && tick && (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (!run)    count_q <= reload;
    else if (tick)    count_q <= step(count_q, reload);
  end

  assign count = count_q;
endmodule

// File: rtl/cti_irq_drive.sv
module cti_irq_drive
  import cti_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq_oe
);
  logic flag_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, set, clr);
      oe_q   <= flag_q && ie;
    end
  end

  assign flag   = flag_q;
  assign irq_oe = oe_q;
endmodule

// File: rtl/cycle_timer_irq.sv
module cycle_timer_irq
  import cti_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_ticks,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_oe
);
  logic             run_q, ie_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             sel_tick, uflow, flag, clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ie_q     <= 1'b0;
      sel_q    <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_CTRL) begin
        run_q <= wr_data[CTRL_RUN_BIT];
        ie_q  <= wr_data[CTRL_IE_BIT];
        sel_q <= wr_data[CTRL_SEL_LSB +: SEL_W];
      end
      if (wr_addr == REG_RELOAD) reload_q <= wr_data;
    end
  end

  always_comb clr_wr = wr_en && (wr_addr == REG_STAT) && !wr_data[STAT_FLAG_BIT];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_data[CTRL_RUN_BIT] = run_q;
        rd_data[CTRL_IE_BIT]  = ie_q;
        rd_data[CTRL_SEL_LSB +: SEL_W] = sel_q;
      end
      REG_RELOAD: rd_data = reload_q;
      REG_STAT:   rd_data[STAT_FLAG_BIT] = flag;
      default:    rd_data = '0;
    endcase
  end

  cti_tick_select #(.N_SRC(N_SRC)) u_sel (
    .ticks(src_ticks), .sel(sel_q), .tick(sel_tick)
  );

  cti_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(sel_tick),
    .reload(reload_q), .count(count), .uflow(uflow)
  );

  cti_irq_drive u_irq (
    .clk(clk), .rst_n(rst_n), .set(uflow), .clr(clr_wr), .ie(ie_q),
    .flag(flag), .irq_oe(irq_oe)
  );
endmodule

// File: rtl/cycle_timer_irq_chk.sv
module cycle_timer_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ie,
  input logic             flag,
  input logic             irq_oe,
  input logic             uflow,
  input logic             clr_wr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> $past(flag && ie)); // R6
  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ie) |=> irq_oe); // R7
  AST_FLAG_FROM_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(uflow)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag); // R5
  AST_ZERO_RELOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && reload == '0 && count == '0) |=> (count == '0 && !$rose(flag))); // R4
  AST_STOPPED_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !$rose(flag)); // R8
endmodule

bind cycle_timer_irq cycle_timer_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .ie(ie_q), .flag(flag),
  .irq_oe(irq_oe), .uflow(uflow), .clr_wr(clr_wr), .count(count),
  .reload(reload_q)
);

// File: tb/sim_cycle_timer_irq.sv
module sim_cycle_timer_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_ticks = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_oe;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cycle_timer_irq u0 (
    .clk(clk), .rst_n(rst_n), .src_ticks(src_ticks), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_oe(irq_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl_word(input bit run, input bit ie, input int sel);
    return 8'((sel << 2) | (int'(ie) << 1) | int'(run));
  endfunction

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int src);
    src_ticks = 4'(1 << src);
    @(negedge clk);
    src_ticks = '0;
  endtask

  // one selected tick, preceded by pulses on every other source
  task automatic sel_tick(input int sel);
    for (int s = 0; s < 4; s++) if (s != sel) pulse(s);
    pulse(sel);
  endtask

  task automatic rd(input int addr, output int val);
    rd_addr = 2'(addr);
    #1;
    val = int'(rd_data);
  endtask

  task automatic flag_is(input string req, input int exp);
    int v;
    rd(2, v);
    check(req, v & 1, exp);
  endtask

  initial begin
    int v;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 reload", v, 0);
    flag_is("R1 flag", 0);
    check("R1 irq_oe", int'(irq_oe), 0);

    // R10 readback
    wr(0, ctrl_word(0, 1, 3)); rd(0, v); check("R10 ctrl readback", v, 8'h0E);
    wr(1, 8'hA5);              rd(1, v); check("R10 reload readback", v, 8'hA5);
    wr(0, 0);

    // R2/R3/R6 sweep: every source, reload 1..16, two periods each
    for (int sel = 0; sel < 4; sel++) begin
      for (int n = 1; n <= 16; n++) begin
        wr(1, n);
        wr(0, ctrl_word(1, 1, sel));
        for (int p = 0; p < 2; p++) begin
          for (int k = 1; k < n; k++) sel_tick(sel);
          flag_is("R2 R3 flag before last tick", 0);
          sel_tick(sel);
          flag_is("R2 R3 flag on N-th tick", 1);
          check("R6 irq_oe not yet", int'(irq_oe), 0);
          idle(1);
          check("R6 irq_oe asserted", int'(irq_oe), 1);
          wr(2, 0);
          flag_is("R5 cleared", 0);
          idle(1);
          check("R6 irq_oe released", int'(irq_oe), 0);
        end
        wr(0, 0);
      end
    end

    // R3 full-scale reload on 64 Hz source
    wr(1, 255); wr(0, ctrl_word(1, 0, 1));
    for (int k = 1; k < 255; k++) pulse(1);
    flag_is("R3 255 before", 0);
    pulse(1);
    flag_is("R3 255 event", 1);
    wr(0, 0); wr(2, 0);

    // R4 zero reload
    wr(1, 0); wr(0, ctrl_word(1, 1, 0));
    for (int k = 0; k < 40; k++) pulse(0);
    flag_is("R4 zero reload", 0);
    check("R4 irq_oe", int'(irq_oe), 0);
    wr(0, 0);

    // R5 writing 1 has no effect; R7 late enable
    wr(1, 1); wr(0, ctrl_word(1, 0, 0)); pulse(0);
    flag_is("R5 set", 1);
    wr(2, 1); flag_is("R5 write one keeps", 1);
    idle(2); check("R6 ie off no irq", int'(irq_oe), 0);
    wr(0, ctrl_word(0, 1, 0));
    check("R7 one clock after enable write", int'(irq_oe), 0);
    idle(1); check("R7 pending drives irq", int'(irq_oe), 1);
    wr(0, ctrl_word(0, 0, 0)); idle(1);
    check("R6 ie falls releases irq", int'(irq_oe), 0);
    flag_is("R8 stop keeps pending flag", 1);
    wr(2, 0);

    // R8 stop mid-period then restart runs full period
    wr(1, 4); wr(0, ctrl_word(1, 0, 2));
    pulse(2); pulse(2);
    wr(0, ctrl_word(0, 0, 2));
    for (int k = 0; k < 10; k++) pulse(2);
    flag_is("R8 stopped no event", 0);
    wr(0, ctrl_word(1, 0, 2));
    for (int k = 0; k < 3; k++) pulse(2);
    flag_is("R8 restart full period before", 0);
    pulse(2);
    flag_is("R8 restart full period event", 1);
    wr(0, 0); wr(2, 0);

    // R9 reload change while running
    wr(1, 4); wr(0, ctrl_word(1, 0, 3));
    pulse(3);
    wr(1, 2);
    pulse(3); pulse(3);
    flag_is("R9 old period continues", 0);
    pulse(3);
    flag_is("R9 old period ends", 1);
    wr(2, 0);
    pulse(3);
    flag_is("R9 new period before", 0);
    pulse(3);
    flag_is("R9 new period event", 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule